// File: doc/BRIEF.md
# Wide-Transfer Target Acknowledge Unit

This unit sits in the target side of a PCI interface. It decides whether the transaction now on the bus will move data over all eight byte lanes or over the lower four. It makes that decision only when the initiator asked for wide transfers when the transaction began and the address decode selected this target. It then answers the initiator's wide request with an active-low acknowledge. The acknowledge follows the target's own device-select timing exactly, and afterwards the unit drives it high for one clock before it lets go of the line.

Once the lane mode is settled, the unit gates the rest of the target. It enables the output drivers of the upper address/data lanes during read data phases. It enables capture of upper-lane write data. It generates the even parity bit for the upper lanes, which is driven one clock after the data. On writes it checks the incoming upper parity bit and flags a mismatch. When no wide request was seen, every upper-lane function stays off for the whole transaction.

Top module: `wide_xfer_ack`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit returns to idle: `wide_mode`, `wide_ack_oe`, `hi_ad_oe`, `hi_par_oe`, `hi_par_o`, `hi_wr_en` and `par_err` are 0, and `wide_ack_o` is 1 unless `sel_int` is high in a later wide transaction.
- R2: The transaction start is the first rising edge at which `bus_cyc_n` is low after an edge at which it was high; the first edge after reset also counts. At that edge `wide_mode` becomes 1 exactly when `wide_req_n` is 0 and `addr_hit` is 1, and 0 otherwise. Values of `wide_req_n` and `addr_hit` at any other edge have no effect.
- R3: `wide_mode` keeps its value until a rising edge at which `bus_cyc_n` is high and `sel_int` is low. At that edge it clears to 0.
- R4: `wide_ack_o` is 0 (acknowledge asserted) in exactly the cycles where `sel_int` is 1 and `wide_mode` is 1. It is never 0 when `wide_mode` is 0.
- R5: `wide_ack_oe` is 1 while the acknowledge is asserted, and for one further cycle after it deasserts. In that extra cycle `wide_ack_o` is 1. In all other cycles `wide_ack_oe` is 0.
- R6: `hi_ad_oe` equals `rd_drive` AND `wide_mode` in the same cycle.
- R7: `hi_par_oe` at each edge takes the value `hi_ad_oe` had before that edge. `hi_par_o` at each edge takes the XOR of all bits of `hi_ad_in` and `hi_cbe_n`, so that those lanes together with the parity bit hold an even number of ones.
- R8: `hi_wr_en` equals `wr_strobe` AND `wide_mode` in the same cycle.
- R9: Suppose `wr_strobe` and `wide_mode` are both 1 at edge k. If `hi_par_in` at edge k+1 differs from the XOR of `hi_ad_in` and `hi_cbe_n` at edge k, then `par_err` is 1 for the cycle after edge k+1; otherwise it is 0.
- R10: A write data phase taken while `wide_mode` is 0 never raises `par_err`, whatever the upper lanes and `hi_par_in` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cyc_n | input | 1 | Transaction framing from the initiator, active low |
| wide_req_n | input | 1 | Initiator's request for eight-lane transfers, active low |
| addr_hit | input | 1 | Address decode selected this target |
| sel_int | input | 1 | Internal device-select timing, high while the target claims |
| rd_drive | input | 1 | Lower-lane read data drive enable, past turnaround |
| wr_strobe | input | 1 | Write data phase completes this clock |
| hi_ad_in | input | AD_W | Upper address/data lanes as seen on the bus |
| hi_cbe_n | input | AD_W/8 | Upper byte enables as seen on the bus |
| hi_par_in | input | 1 | Upper-lane parity bit from the bus |
| wide_ack_o | output | 1 | Acknowledge output value, active low |
| wide_ack_oe | output | 1 | Acknowledge output driver enable |
| wide_mode | output | 1 | 1 = eight-lane mode, 0 = four-lane mode |
| hi_ad_oe | output | 1 | Upper address/data driver enable |
| hi_par_oe | output | 1 | Upper parity driver enable |
| hi_par_o | output | 1 | Generated upper parity bit |
| hi_wr_en | output | 1 | Upper-lane write capture enable |
| par_err | output | 1 | Upper parity mismatch on a wide write, one-cycle pulse |

## Verification
The acknowledge value and enable, the upper drive enable and the write capture enable are combinational. They are due in the same cycle as the inputs that cause them. The lane mode, the release cycle of the acknowledge, the parity enable and the parity bit change one edge after their cause. The parity error appears two edges after the write data it covers. The bench applies inputs just after each falling edge. It compares every output one time unit later against a cycle model that it advances at each rising edge, so each expected value lines up with the register count on its path.

// File: rtl/wide_ack_pkg.sv
// Shared types for the wide-transfer target acknowledge unit.
// Assumes nothing beyond a single bus clock domain.
package wide_ack_pkg;
    typedef enum logic {
        LANES_NARROW = 1'b0,
        LANES_WIDE   = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/wide_req_sampler.sv
// Decides the lane mode of each transaction.
// The wide request and the address hit are taken once, at the first edge
// where the framing signal is low after an idle edge. The result is held
// until framing and device-select are both released.
// Assumes the internal device-select never rises at the start edge.
module wide_req_sampler
    import wide_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cyc_n,
    input  logic       wide_req_n,
    input  logic       addr_hit,
    input  logic       sel_int,
    output lane_mode_e mode
);
    logic idle_q;
    logic start;

    // Remember whether framing was high at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b1;
        else        idle_q <= bus_cyc_n;
    end

    assign start = !bus_cyc_n && idle_q;

    // Latch the lane decision at start and clear it once the bus goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= LANES_NARROW;
        else if (start)
            mode <= (!wide_req_n && addr_hit) ? LANES_WIDE : LANES_NARROW;
        else if (bus_cyc_n && !sel_int)
            mode <= LANES_NARROW;
    end

    assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cyc_n && !idle_q) |=> $stable(mode));

    assert_idle_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_n && !sel_int) |=> (mode == LANES_NARROW));

    assert_no_req_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cyc_n && idle_q && wide_req_n) |=> (mode == LANES_NARROW));
endmodule

// File: rtl/wide_ack_drv.sv
// Drives the active-low wide acknowledge.
// The acknowledge is asserted while device-select is active in wide mode.
// After it deasserts, the line is driven high for one more clock and then
// released. Assumes sel_int carries the target's device-select timing.
module wide_ack_drv
    import wide_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lane_mode_e mode,
    input  logic       sel_int,
    output logic       ack_o,
    output logic       ack_oe
);
    logic ack_active;
    logic rel_q;

    assign ack_active = sel_int && (mode == LANES_WIDE);

    // Keep the driver on for one cycle after the acknowledge deasserts.
    always_ff @(posedge clk) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= ack_active;
    end

    assign ack_o  = !ack_active;
    assign ack_oe = ack_active || rel_q;

    assert_ack_needs_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (mode == LANES_WIDE));

    assert_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_active) |-> (ack_oe && ack_o));

    assert_oe_off_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LANES_NARROW && $past(mode) == LANES_NARROW) |-> !ack_oe);
endmodule

// File: rtl/upper_lane_ctl.sv
// Gates the upper byte lanes by the lane mode.
// It produces the read drive and write capture enables, generates upper
// parity one clock after the data, and checks write parity that arrives
// one clock after the data. Parity is even over the data and byte enables.
// Assumes AD_W is a multiple of 8.
module upper_lane_ctl
    import wide_ack_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_mode_e        mode,
    input  logic              rd_drive,
    input  logic              wr_strobe,
    input  logic [AD_W-1:0]   hi_ad_in,
    input  logic [AD_W/8-1:0] hi_cbe_n,
    input  logic              hi_par_in,
    output logic              hi_ad_oe,
    output logic              hi_par_oe,
    output logic              hi_par_o,
    output logic              hi_wr_en,
    output logic              par_err
);
    localparam int LANES = AD_W / 8;

    logic [LANES-1:0] lane_par;
    logic             full_par;
    logic             wide;
    logic             chk_pend;
    logic             calc_q;

    // Parity per byte lane, including that lane's byte enable.
    for (genvar i = 0; i < LANES; i++) begin : g_lane_par
        assign lane_par[i] = (^hi_ad_in[8*i +: 8]) ^ hi_cbe_n[i];
    end
    assign full_par = ^lane_par;

    assign wide     = (mode == LANES_WIDE);
    assign hi_ad_oe = rd_drive && wide;
    assign hi_wr_en = wr_strobe && wide;

    // Generated parity and its enable trail the data by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_par_oe <= 1'b0;
            hi_par_o  <= 1'b0;
        end else begin
            hi_par_oe <= hi_ad_oe;
            hi_par_o  <= full_par;
        end
    end

    // Hold the expected write parity, then compare with the arriving bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_pend <= 1'b0;
            calc_q   <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            chk_pend <= hi_wr_en;
            calc_q   <= full_par;
            par_err  <= chk_pend && (calc_q != hi_par_in);
        end
    end

    assert_hi_oe_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ad_oe |-> wide);

    assert_par_oe_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_par_oe |-> $past(hi_ad_oe));

    assert_wr_en_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_en |-> wide);

    assert_err_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> ($past(mode, 2) == LANES_WIDE));
endmodule

// File: rtl/wide_xfer_ack.sv
// Top of the wide-transfer target acknowledge unit.
// It ties together the request sampler, the acknowledge driver and the
// upper-lane control. Assumes a single clock and a synchronous active-low reset.
module wide_xfer_ack
    import wide_ack_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cyc_n,
    input  logic              wide_req_n,
    input  logic              addr_hit,
    input  logic              sel_int,
    input  logic              rd_drive,
    input  logic              wr_strobe,
    input  logic [AD_W-1:0]   hi_ad_in,
    input  logic [AD_W/8-1:0] hi_cbe_n,
    input  logic              hi_par_in,
    output logic              wide_ack_o,
    output logic              wide_ack_oe,
    output logic              wide_mode,
    output logic              hi_ad_oe,
    output logic              hi_par_oe,
    output logic              hi_par_o,
    output logic              hi_wr_en,
    output logic              par_err
);
    lane_mode_e mode;

    wide_req_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cyc_n  (bus_cyc_n),
        .wide_req_n (wide_req_n),
        .addr_hit   (addr_hit),
        .sel_int    (sel_int),
        .mode       (mode)
    );

    wide_ack_drv u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .sel_int (sel_int),
        .ack_o   (wide_ack_o),
        .ack_oe  (wide_ack_oe)
    );

    upper_lane_ctl #(.AD_W(AD_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .rd_drive  (rd_drive),
        .wr_strobe (wr_strobe),
        .hi_ad_in  (hi_ad_in),
        .hi_cbe_n  (hi_cbe_n),
        .hi_par_in (hi_par_in),
        .hi_ad_oe  (hi_ad_oe),
        .hi_par_oe (hi_par_oe),
        .hi_par_o  (hi_par_o),
        .hi_wr_en  (hi_wr_en),
        .par_err   (par_err)
    );

    assign wide_mode = (mode == LANES_WIDE);

    assert_ack_never_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_ack_o |-> wide_mode);
endmodule

// File: tb/tb_wide_xfer_ack.sv
module tb_wide_xfer_ack;
    localparam int CLK_PERIOD = 10;
    localparam int AD_W = 32;
    localparam int BE_W = AD_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_cyc_n = 1'b1, wide_req_n = 1'b1, addr_hit = 1'b0, sel_int = 1'b0;
    logic rd_drive = 1'b0, wr_strobe = 1'b0, hi_par_in = 1'b0;
    logic [AD_W-1:0] hi_ad_in = '0;
    logic [BE_W-1:0] hi_cbe_n = '0;
    logic wide_ack_o, wide_ack_oe, wide_mode, hi_ad_oe, hi_par_oe, hi_par_o, hi_wr_en, par_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench cycle model state
    bit m_idle, m_mode, m_rel, m_paroe, m_paro, m_pend, m_calc, m_err;

    wide_xfer_ack #(.AD_W(AD_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_cyc_n(bus_cyc_n), .wide_req_n(wide_req_n),
        .addr_hit(addr_hit), .sel_int(sel_int), .rd_drive(rd_drive),
        .wr_strobe(wr_strobe), .hi_ad_in(hi_ad_in), .hi_cbe_n(hi_cbe_n),
        .hi_par_in(hi_par_in), .wide_ack_o(wide_ack_o), .wide_ack_oe(wide_ack_oe),
        .wide_mode(wide_mode), .hi_ad_oe(hi_ad_oe), .hi_par_oe(hi_par_oe),
        .hi_par_o(hi_par_o), .hi_wr_en(hi_wr_en), .par_err(par_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit even_bit(logic [AD_W-1:0] ad, logic [BE_W-1:0] be);
        return bit'(($countones(ad) + $countones(be)) % 2);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model and the inputs now applied.
    task automatic check_all();
        bit act_now;
        act_now = sel_int && m_mode;
        chk("R2 R3 wide_mode", wide_mode, m_mode);
        chk("R4 wide_ack_o", wide_ack_o, !act_now);
        chk("R5 wide_ack_oe", wide_ack_oe, act_now || m_rel);
        chk("R6 hi_ad_oe", hi_ad_oe, rd_drive && m_mode);
        chk("R7 hi_par_oe", hi_par_oe, m_paroe);
        chk("R7 hi_par_o", hi_par_o, m_paro);
        chk("R8 hi_wr_en", hi_wr_en, wr_strobe && m_mode);
        chk("R9 par_err", par_err, m_err);
    endtask

    // Advance the model at a rising edge, using the inputs held across it.
    task automatic model_edge();
        bit n_mode;
        if (!rst_n) begin
            m_idle = 1; m_mode = 0; m_rel = 0; m_paroe = 0;
            m_paro = 0; m_pend = 0; m_calc = 0; m_err = 0;
        end else begin
            n_mode = m_mode;
            if (!bus_cyc_n && m_idle) n_mode = !wide_req_n && addr_hit;
            else if (bus_cyc_n && !sel_int) n_mode = 0;
            m_err   = m_pend && (m_calc != hi_par_in);
            m_pend  = wr_strobe && m_mode;
            m_calc  = even_bit(hi_ad_in, hi_cbe_n);
            m_paro  = m_calc;
            m_paroe = rd_drive && m_mode;
            m_rel   = sel_int && m_mode;
            m_idle  = bus_cyc_n;
            m_mode  = n_mode;
        end
    endtask

    task automatic cycle(bit cyc, bit req, bit hit, bit sel, bit rd, bit wr,
                         logic [AD_W-1:0] ad, logic [BE_W-1:0] be, bit par);
        @(negedge clk);
        bus_cyc_n = cyc; wide_req_n = req; addr_hit = hit; sel_int = sel;
        rd_drive = rd; wr_strobe = wr; hi_ad_in = ad; hi_cbe_n = be; hi_par_in = par;
        #1;
        if (rst_n) check_all();
        @(posedge clk);
        model_edge();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd24681357));
        rst_n = 1'b0;
        repeat (3) cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);
        rst_n = 1'b1;
        // R1: idle outputs straight after reset
        #1;
        chk("R1 wide_mode", wide_mode, 1'b0);
        chk("R1 wide_ack_oe", wide_ack_oe, 1'b0);
        chk("R1 hi_par_oe", hi_par_oe, 1'b0);
        chk("R1 par_err", par_err, 1'b0);

        // Wide read: request and hit at start, then late request change ignored (R2)
        cycle(0, 0, 1, 0, 0, 0, '0, '0, 0);
        cycle(0, 1, 0, 1, 0, 0, '0, '0, 0);
        chk("R2 mode held after late request change", wide_mode, 1'b1);
        chk("R4 acknowledge asserted", wide_ack_o, 1'b0);
        cycle(0, 1, 0, 1, 1, 0, 32'hA5A5_0F0F, 4'h3, 0);
        cycle(1, 1, 0, 1, 1, 0, 32'h1234_5678, 4'h0, 0);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);
        chk("R5 release cycle drives high", wide_ack_oe && wide_ack_o, 1'b1);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);
        chk("R3 mode cleared at idle", wide_mode, 1'b0);
        chk("R5 acknowledge released", wide_ack_oe, 1'b0);

        // Request without hit stays narrow (R2)
        cycle(0, 0, 0, 0, 0, 0, '0, '0, 0);
        cycle(0, 0, 1, 1, 1, 0, '0, '0, 0);
        chk("R2 no hit keeps narrow", wide_mode, 1'b0);
        chk("R6 no upper drive when narrow", hi_ad_oe, 1'b0);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);

        // Narrow write with bad parity: no error (R10)
        cycle(0, 1, 1, 0, 0, 0, '0, '0, 0);
        cycle(0, 1, 1, 1, 0, 1, 32'h0000_0001, 4'h0, 0);
        cycle(1, 1, 1, 1, 0, 0, '0, '0, 0);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);
        chk("R10 narrow write raises no error", par_err, 1'b0);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);

        // Wide write with bad parity: error two edges later (R9)
        cycle(0, 0, 1, 0, 0, 0, '0, '0, 0);
        cycle(0, 0, 1, 1, 0, 1, 32'h0000_0003, 4'h1, 0);
        chk("R8 capture enabled", hi_wr_en, 1'b1);
        cycle(1, 0, 1, 1, 0, 0, '0, '0, 0);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);
        chk("R9 mismatch flagged", par_err, 1'b1);
        cycle(1, 1, 0, 0, 0, 0, '0, '0, 0);

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom % 10) < 4, ($urandom % 2) == 1, ($urandom % 4) != 0,
                  ($urandom % 3) != 0, ($urandom % 2) == 1, ($urandom % 2) == 1,
                  $urandom, 4'($urandom), ($urandom % 2) == 1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule